// File: doc/BRIEF.md
# Xoroshiro128+ Jump-Ahead Engine

This block moves a xoroshiro128+ generator state forward by the equivalent of 2^64 ordinary steps. The caller gives a seed and receives a new state. Applying the engine again to its own result gives another 2^64 steps. A single seed can therefore be split into many subsequences that never overlap, for example one for each generator in a parallel array.

The engine does not step 2^64 times. It walks a fixed 128-bit jump polynomial, one bit per clock, and advances a private copy of the generator by one ordinary step on every clock. Two 64-bit accumulators start at zero. When the current polynomial bit is 1, the state that is current before that step is XORed into them. After the last bit, the accumulators become the new state.

Top module: `xo_jump_engine`

## Requirements
- R1: When `start` is high on a clock edge while `busy` is low, the engine captures `seed_lo`/`seed_hi` as the working state and clears both accumulators. `busy` is high in the next cycle.
- R2: `busy` stays high for exactly 128 consecutive cycles per jump. One polynomial bit is consumed in each of these cycles.
- R3: `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R4: The polynomial is the 128-bit value {0xd86b048b86aa9922, 0xbeac0467eba5facb}. Its bits are consumed from bit 0 to bit 127, so the low word is consumed first, from its bit 0 upward. For each bit that is 1, the current state is XORed lane by lane into the accumulators before that cycle's step. After bit 127, `jump_lo`/`jump_hi` hold the accumulators.
- R5: One ordinary step works as follows. Let m = hi ^ lo. The new lo is rotl(lo,55) ^ m ^ (m<<14). The new hi is rotl(m,36). The engine takes this step after every polynomial bit, whether the bit is 0 or 1.
- R6: A `start` that arrives while `busy` is high is ignored. It affects neither the result nor the 128-cycle length of the jump in progress.
- R7: `jump_lo`/`jump_hi` change only in the cycle where `done` is high, and hold their value at all other times.
- R8: Synchronous reset drives `busy` and `done` low and clears `jump_lo`/`jump_hi` to zero.
- R9: An all-zero seed gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a jump from the presented seed |
| seed_lo | input | 64 | Seed lane lo (first state word) |
| seed_hi | input | 64 | Seed lane hi (second state word) |
| busy | output | 1 | A jump is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| jump_lo | output | 64 | Jumped state, lane lo |
| jump_hi | output | 64 | Jumped state, lane hi |

## Verification
The bench compares each result with an independent loop model for several seeds. These include an all-zero seed, a single set bit, and a chain in which each result is fed back as the next seed. A reversed walk order, a step taken before the XOR instead of after it, or a wrong shift or rotate amount would produce a different state here.

A second `start` with a different seed is injected partway through a jump. A design that restarted or reloaded would give a wrong result or stretch `busy` past 128 cycles. The bench also counts `busy` cycles and watches the outputs between jumps. This catches an off-by-one in the length of the walk, a `done` that lasts more than one cycle, and an output that moves without `done`.

// File: rtl/xo_jump_pkg.sv
package xo_jump_pkg;
  localparam int unsigned LANE_W = 64;
  typedef logic [LANE_W-1:0] lane_t;
  typedef struct packed {
    lane_t hi;
    lane_t lo;
  } gen_state_t;
endpackage

// File: rtl/xo_step.sv
module xo_step
  import xo_jump_pkg::*;
#(
  parameter int unsigned ROT_A = 55,
  parameter int unsigned SHL_B = 14,
  parameter int unsigned ROT_C = 36
) (
  input  gen_state_t cur,
  output gen_state_t nxt
);
  localparam int unsigned W = LANE_W;
  lane_t mix;

  always_comb begin
    mix    = cur.hi ^ cur.lo;
    nxt.lo = ((cur.lo << ROT_A) | (cur.lo >> (W - ROT_A))) ^ mix ^ (mix << SHL_B);
    nxt.hi = (mix << ROT_C) | (mix >> (W - ROT_C));
  end
endmodule

// File: rtl/xo_jump_seq.sv
module xo_jump_seq #(
  parameter int unsigned POLY_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic busy,
  output logic last
);
  localparam int unsigned IDX_W = $clog2(POLY_LEN);
  logic [IDX_W-1:0] idx;

  assign load = start && !busy;
  assign last = busy && (idx == IDX_W'(POLY_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      busy <= !last;
      idx  <= idx + 1'b1;
    end
  end

  a_r1_launch: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && idx == '0));
  a_r2_keep_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  a_r2_end_busy: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/xo_jump_engine.sv
module xo_jump_engine
  import xo_jump_pkg::*;
#(
  parameter int unsigned POLY_LEN = 128,
  parameter logic [POLY_LEN-1:0] JUMP_POLY =
    {64'hd86b048b86aa9922, 64'hbeac0467eba5facb},
  parameter int unsigned ROT_A = 55,
  parameter int unsigned SHL_B = 14,
  parameter int unsigned ROT_C = 36
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [63:0] seed_lo,
  input  logic [63:0] seed_hi,
  output logic        busy,
  output logic        done,
  output logic [63:0] jump_lo,
  output logic [63:0] jump_hi
);
  localparam int unsigned NLANE = 2;

  logic                load, last;
  logic [POLY_LEN-1:0] poly_sr;
  gen_state_t          work, work_nxt;
  lane_t               acc      [NLANE];
  lane_t               cur_lane [NLANE];
  lane_t               seed_l   [NLANE];
  lane_t               acc_nxt  [NLANE];
  lane_t               res      [NLANE];

  xo_jump_seq #(.POLY_LEN(POLY_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .busy(busy), .last(last)
  );

  xo_step #(.ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C)) u_step (
    .cur(work), .nxt(work_nxt)
  );

  assign cur_lane[0] = work.lo;
  assign cur_lane[1] = work.hi;
  assign seed_l[0]   = seed_lo;
  assign seed_l[1]   = seed_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      work    <= '0;
      poly_sr <= '0;
    end else if (load) begin
      work    <= '{hi: seed_hi, lo: seed_lo};
      poly_sr <= JUMP_POLY;
    end else if (busy) begin
      work    <= work_nxt;
      poly_sr <= poly_sr >> 1;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign acc_nxt[g] = acc[g] ^ (poly_sr[0] ? cur_lane[g] : '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        acc[g] <= '0;
        res[g] <= '0;
      end else if (load) begin
        acc[g] <= '0;
      end else if (busy) begin
        acc[g] <= acc_nxt[g];
        if (last) res[g] <= acc_nxt[g];
      end
    end

    a_r9_zero_seed_stays: assert property (@(posedge clk) disable iff (rst)
      (load && seed_l[g] == '0 && seed_l[1-g] == '0) |=> (cur_lane[g] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= last;
  end

  assign jump_lo = res[0];
  assign jump_hi = res[1];

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({jump_hi, jump_lo}) |-> done);
endmodule

// File: tb/test_xo_jump_engine.sv
module test_xo_jump_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] seed_lo = '0, seed_hi = '0;
  logic        busy, done;
  logic [63:0] jump_lo, jump_hi;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_q[$];
  int busy_cycles = 0;
  logic prev_done = 1'b0;
  logic [127:0] held = '0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  xo_jump_engine i_xo_jump_engine (
    .clk(clk), .rst(rst), .start(start),
    .seed_lo(seed_lo), .seed_hi(seed_hi),
    .busy(busy), .done(done), .jump_lo(jump_lo), .jump_hi(jump_hi)
  );

  function automatic logic [63:0] rl(input logic [63:0] x, input int k);
    return (x << k) | (x >> (64 - k));
  endfunction

  // R5 reference step; state packed as {hi, lo}
  function automatic logic [127:0] ref_step(input logic [127:0] s);
    logic [63:0] a, b;
    a = s[63:0];
    b = s[127:64] ^ a;
    return {rl(b, 36), rl(a, 55) ^ b ^ (b << 14)};
  endfunction

  // R4 reference jump loop
  function automatic logic [127:0] ref_jump(input logic [127:0] s);
    logic [63:0] words [2];
    logic [127:0] acc, st;
    words[0] = 64'hbeac0467eba5facb;
    words[1] = 64'hd86b048b86aa9922;
    acc = '0;
    st  = s;
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 64; b++) begin
        if (words[w][b]) acc = acc ^ st;
        st = ref_step(st);
      end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_jump(input logic [127:0] seed, input bit disturb,
                          output logic [127:0] result);
    result = ref_jump(seed);
    @(negedge clk);
    while (busy) @(negedge clk);
    seed_lo = seed[63:0];
    seed_hi = seed[127:64];
    start = 1'b1;
    exp_q.push_back(result);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (40) @(negedge clk);
      seed_lo = 64'h0123456789abcdef;
      seed_hi = 64'hfedcba9876543210;
      start = 1'b1;   // R6: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) busy_cycles++;
      if (done) begin
        check(busy_cycles == 128, "R2 busy length", 128'(busy_cycles), 128'd128);
        check(!busy, "R3 done while busy low", 128'(busy), 128'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", {jump_hi, jump_lo}, '0);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          check({jump_hi, jump_lo} == e, "R4 jump result", {jump_hi, jump_lo}, e);
        end
        busy_cycles = 0;
        held = {jump_hi, jump_lo};
      end else begin
        check({jump_hi, jump_lo} == held, "R7 result hold", {jump_hi, jump_lo}, held);
      end
      if (prev_done) check(!done, "R3 done single cycle", 128'(done), 128'd0);
      prev_done = done;
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && jump_lo == 0 && jump_hi == 0, "R8 reset state",
          {busy, done, jump_hi[61:0], jump_lo}, '0);
    mon_on = 1'b1;
    // R1 R4 R5: ordinary seeds
    run_jump({64'h0000000000000000, 64'h0000000000000001}, 1'b0, r);
    run_jump({64'hdeadbeefcafef00d, 64'h123456789abcdef0}, 1'b0, r);
    // R9 zero seed
    run_jump('0, 1'b0, r);
    check(r == '0, "R9 zero model", r, '0);
    // R6 disturbing start mid-jump
    run_jump({64'h8000000000000000, 64'h5555aaaa5555aaaa}, 1'b1, r);
    // chaining: result becomes next seed
    run_jump({64'h0f0f0f0f0f0f0f0f, 64'h3c3c3c3c3c3c3c3c}, 1'b0, r);
    run_jump(r, 1'b0, r);
    run_jump(r, 1'b1, r);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R1 every start produced a result", 128'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule